// File: doc/BRIEF.md
# Transmit Byte FIFO with Packed Status Word

This block sits between a host microcontroller and a transmitter datapath. The host pushes bytes into a 32-entry first-in first-out store. The transmitter pulls them out one per request. The head byte is presented combinationally, and a request is granted in the same cycle whenever the store holds data.

A read-only 16-bit status word summarises the block. It packs four things: two sticky error flags that clear when the host reads the word, the live fill count, a low-water trigger flag, and a registered copy of the transmitter state code. Two interrupt lines come out of the block. The error line is high while either sticky flag is set. The trigger line follows the low-water flag. A 5-bit threshold register, written by the host, sets the low-water point.

Errors are reported only. Neither an overflow nor an underflow flushes the store or stops a transmission.

Top module: `tx_fifo_status`

## Requirements
- R1: After reset the status word reads 0x0080: fill 0, trigger set, both sticky flags clear, state 0. In the same condition err_irq_o is 0 and trig_irq_o is 1.
- R2: Bytes leave in the order they were written, up to 32 bytes. Status bits 13:8 report the current byte count, which lies between 0 and 32 inclusive.
- R3: A write while the store holds 32 bytes is discarded and sets status bit 15 (overflow). A write and a granted pull in the same cycle at 32 bytes is a pull then a write: it raises no overflow and the count stays 32.
- R4: A pull request with stream_i=1 while the store is empty is not granted (rd_ok_o=0). It sets status bit 14 (underflow) at the next clock edge.
- R5: A pull request with stream_i=0 (burst mode) on an empty store sets no flag.
- R6: A cycle with stat_rd_i=1 clears bits 15 and 14 at the next edge. If a flag-setting event occurs in that same cycle, the flag stays set.
- R7: Status bit 7 is 1 exactly when the fill count is less than or equal to the threshold register. The threshold register is loaded from thr_data_i when thr_we_i=1 and resets to 0.
- R8: err_irq_o equals status bit 15 OR bit 14. trig_irq_o equals status bit 7.
- R9: Status bits 3:0 show tx_state_i as registered on the previous edge. The codes are: 0 idle, 1 building burst buffer, 2 burst buffer ready, 3 pending, 4 in progress, 5 aborted on carrier, 6 aborted on buffer not ready, 7 aborted on message too long, 8 chained message. Bits 6:4 always read 0.
- R10: A set flag has no effect on data flow. After an overflow, all 32 stored bytes still come out intact and in order, and the flag stays set until the status word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_req_i | input | 1 | Transmitter pull request |
| stream_i | input | 1 | 1 while a streaming transmission is active; 0 in burst mode |
| rd_data_o | output | 8 | Head byte of the store |
| rd_ok_o | output | 1 | Pull granted this cycle |
| thr_we_i | input | 1 | Threshold register write strobe |
| thr_data_i | input | 5 | Threshold value |
| tx_state_i | input | 4 | Transmitter state code |
| stat_rd_i | input | 1 | Status word read strobe |
| status_o | output | 16 | Packed status word |
| err_irq_o | output | 1 | Error interrupt |
| trig_irq_o | output | 1 | Low-water interrupt |

## Verification
The bench fills the store to exactly 32 bytes and then writes once more. A design that did not guard the full state would wrap its pointers and overwrite the oldest byte, and the drain that follows would return corrupted data. It also writes and pulls in the same cycle while the store is full. A design that checked fullness without accounting for the pull would report a false overflow.

A status read is made in the same cycle as a fresh underflow event. A design that gave the clear priority would lose that error.

The bench also pulls from an empty store in burst mode, which must raise no flag. It then steps the fill level across the threshold, catching a strict-less-than compare or an off-by-one in the count.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  localparam int unsigned STAT_W = 16;

  typedef enum logic [3:0] {
    TXS_IDLE       = 4'd0,
    TXS_BUILD      = 4'd1,
    TXS_BUF_READY  = 4'd2,
    TXS_PENDING    = 4'd3,
    TXS_ACTIVE     = 4'd4,
    TXS_AB_CARRIER = 4'd5,
    TXS_AB_NOTRDY  = 4'd6,
    TXS_AB_TOOLONG = 4'd7,
    TXS_CHAINED    = 4'd8
  } tx_state_e;

  typedef struct packed {
    logic       ovf;
    logic       udf;
    logic [5:0] fill;
    logic       trig;
    logic [2:0] zero;
    tx_state_e  state;
  } tx_status_t;
endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic             pop_o,
  output logic             ovf_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, push;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign pop_o   = rd_i && !empty_o;
  // a pull in the same cycle frees the slot for the write
  assign push    = wr_i && (!full || pop_o);
  assign ovf_o   = wr_i && full && !pop_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push)  wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_o) rd_ptr_q <= nxt(rd_ptr_q);
      if (push && !pop_o)      cnt_q <= cnt_q + 1'b1;
      else if (pop_o && !push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tx_sticky_flags.sv
module tx_sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;  // event beats clear
      else if (clr_i)    q <= 1'b0;
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/tx_status_pack.sv
module tx_status_pack
  import tx_fifo_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned THR_W = 5
) (
  input  logic             ovf_i,
  input  logic             udf_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [THR_W-1:0] thr_i,
  input  tx_state_e        state_i,
  output logic             trig_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned CW = (CNT_W > THR_W) ? CNT_W : THR_W;
  tx_status_t st;

  assign trig_o = (CW'(count_i) <= CW'(thr_i));

  always_comb begin
    st.ovf   = ovf_i;
    st.udf   = udf_i;
    st.fill  = 6'(count_i);
    st.trig  = trig_o;
    st.zero  = '0;
    st.state = state_i;
  end

  assign status_o = st;
endmodule

// File: rtl/tx_fifo_status.sv
module tx_fifo_status
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned THR_W = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_req_i,
  input  logic          stream_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_ok_o,
  input  logic          thr_we_i,
  input  logic [THR_W-1:0] thr_data_i,
  input  logic [3:0]    tx_state_i,
  input  logic          stat_rd_i,
  output logic [15:0]   status_o,
  output logic          err_irq_o,
  output logic          trig_irq_o
);
  logic [CNT_W-1:0] count;
  logic             empty, ovf_ev, udf_ev;
  logic [1:0]       flags;
  logic [THR_W-1:0] thr_q;
  tx_state_e        state_q;

  tx_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i),
    .wdata_i (wr_data_i),
    .rd_i    (rd_req_i),
    .rdata_o (rd_data_o),
    .pop_o   (rd_ok_o),
    .ovf_o   (ovf_ev),
    .empty_o (empty),
    .count_o (count)
  );

  // burst mode loads the whole message first, so no famine is reported
  assign udf_ev = rd_req_i && empty && stream_i;

  tx_sticky_flags #(.N(2)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({ovf_ev, udf_ev}),
    .clr_i  (stat_rd_i),
    .flag_o (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q   <= '0;
      state_q <= TXS_IDLE;
    end else begin
      if (thr_we_i) thr_q <= thr_data_i;
      state_q <= tx_state_e'(tx_state_i);
    end
  end

  tx_status_pack #(.CNT_W(CNT_W), .THR_W(THR_W)) u_pack (
    .ovf_i    (flags[1]),
    .udf_i    (flags[0]),
    .count_i  (count),
    .thr_i    (thr_q),
    .state_i  (state_q),
    .trig_o   (trig_irq_o),
    .status_o (status_o)
  );

  assign err_irq_o = flags[1] | flags[0];
endmodule

// File: rtl/tx_fifo_status_chk.sv
module tx_fifo_status_chk #(
  parameter int unsigned THR_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_req_i,
  input logic             stream_i,
  input logic             rd_ok_o,
  input logic             stat_rd_i,
  input logic [THR_W-1:0] thr_q,
  input logic [15:0]      status_o,
  input logic             err_irq_o,
  input logic             trig_irq_o
);
  logic [5:0] fill;
  assign fill = status_o[13:8];

  p_fill_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= 6'd32);

  p_fill_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == 6'd0) |=> (fill <= 6'd1));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == 6'd32 && wr_en_i && !rd_req_i) |=> (status_o[15] && fill == 6'd32));

  p_full_swap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == 6'd32 && wr_en_i && rd_req_i && !status_o[15]) |=> !status_o[15]);

  p_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == 6'd0 && rd_req_i && stream_i) |=> status_o[14]);

  p_no_grant_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == 6'd0) |-> !rd_ok_o);

  p_burst_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[14] && !stream_i) |=> !status_o[14]);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !wr_en_i && !rd_req_i) |=> (!status_o[15] && !status_o[14]));

  p_trig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] == (fill <= {1'b0, thr_q}));

  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_irq_o == (status_o[15] | status_o[14])) && (trig_irq_o == status_o[7]));

  p_zero_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000);
endmodule

bind tx_fifo_status tx_fifo_status_chk #(.THR_W(THR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_req_i   (rd_req_i),
  .stream_i   (stream_i),
  .rd_ok_o    (rd_ok_o),
  .stat_rd_i  (stat_rd_i),
  .thr_q      (thr_q),
  .status_o   (status_o),
  .err_irq_o  (err_irq_o),
  .trig_irq_o (trig_irq_o)
);

// File: tb/test_tx_fifo_status.sv
module test_tx_fifo_status;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_req_i = 1'b0;
  logic       stream_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_ok_o;
  logic       thr_we_i = 1'b0;
  logic [4:0] thr_data_i = '0;
  logic [3:0] tx_state_i = '0;
  logic       stat_rd_i = 1'b0;
  logic [15:0] status_o;
  logic       err_irq_o, trig_irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  tx_fifo_status i_tx_fifo_status (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic push(input logic [7:0] b);
    wr_en_i = 1'b1; wr_data_i = b;
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic pull_check(input string tag, input logic [7:0] exp);
    rd_req_i = 1'b1;
    #1;
    check({tag, " grant"}, int'(rd_ok_o), 1);
    check({tag, " data"}, int'(rd_data_o), int'(exp));
    cyc();
    rd_req_i = 1'b0;
  endtask

  task automatic read_status();
    stat_rd_i = 1'b1;
    cyc();
    stat_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status", int'(status_o), 'h0080);
    check("R1 err_irq", int'(err_irq_o), 0);
    check("R1 trig_irq", int'(trig_irq_o), 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    check("R2 fill five", int'(status_o[13:8]), 5);
    for (int i = 0; i < 5; i++) pull_check("R2 order", 8'h10 + 8'(i));
    check("R2 fill empty", int'(status_o[13:8]), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 32; i++) push(8'(i * 7 + 3));
    check("R2 fill full", int'(status_o[13:8]), 32);
    check("R3 no ovf yet", int'(status_o[15]), 0);
    push(8'hEE);
    check("R3 ovf set", int'(status_o[15]), 1);
    check("R3 fill stays", int'(status_o[13:8]), 32);
    check("R8 err_irq", int'(err_irq_o), 1);
    for (int i = 0; i < 32; i++) pull_check("R10 drain", 8'(i * 7 + 3));
    check("R10 ovf kept", int'(status_o[15]), 1);
    read_status();
    check("R6 ovf cleared", int'(status_o[15]), 0);
    check("R8 err_irq clr", int'(err_irq_o), 0);
  endtask

  task automatic t_full_swap();
    for (int i = 0; i < 32; i++) push(8'(8'h40 + i));
    wr_en_i = 1'b1; wr_data_i = 8'hA5; rd_req_i = 1'b1;
    cyc();
    wr_en_i = 1'b0; rd_req_i = 1'b0;
    check("R3 swap no ovf", int'(status_o[15]), 0);
    check("R3 swap fill", int'(status_o[13:8]), 32);
    for (int i = 1; i < 32; i++) pull_check("R3 swap drain", 8'(8'h40 + i));
    pull_check("R3 swap tail", 8'hA5);
  endtask

  task automatic t_underflow();
    stream_i = 1'b1;
    rd_req_i = 1'b1;
    #1;
    check("R4 no grant", int'(rd_ok_o), 0);
    cyc();
    rd_req_i = 1'b0;
    check("R4 udf set", int'(status_o[14]), 1);
    check("R8 err_irq udf", int'(err_irq_o), 1);
    stat_rd_i = 1'b1; rd_req_i = 1'b1;
    cyc();
    stat_rd_i = 1'b0; rd_req_i = 1'b0;
    check("R6 event wins", int'(status_o[14]), 1);
    read_status();
    check("R6 udf cleared", int'(status_o[14]), 0);
    stream_i = 1'b0;
  endtask

  task automatic t_burst();
    stream_i = 1'b0;
    rd_req_i = 1'b1;
    cyc(); cyc();
    rd_req_i = 1'b0;
    check("R5 burst quiet", int'(status_o[15:14]), 0);
  endtask

  task automatic t_thresh();
    thr_we_i = 1'b1; thr_data_i = 5'd3;
    cyc();
    thr_we_i = 1'b0;
    for (int i = 0; i < 3; i++) push(8'(i));
    check("R7 at thr", int'(status_o[7]), 1);
    check("R8 trig_irq", int'(trig_irq_o), 1);
    push(8'h03);
    check("R7 above thr", int'(status_o[7]), 0);
    check("R8 trig_irq low", int'(trig_irq_o), 0);
    for (int i = 0; i < 4; i++) pull_check("R7 drain", 8'(i));
    thr_we_i = 1'b1; thr_data_i = 5'd0;
    cyc();
    thr_we_i = 1'b0;
    check("R7 empty thr0", int'(status_o[7]), 1);
    push(8'h55);
    check("R7 one thr0", int'(status_o[7]), 0);
    pull_check("R7 drain2", 8'h55);
  endtask

  task automatic t_state();
    for (int s = 0; s <= 8; s++) begin
      tx_state_i = 4'(s);
      cyc();
      check("R9 state", int'(status_o[3:0]), s);
      check("R9 zero bits", int'(status_o[6:4]), 0);
    end
    tx_state_i = '0;
    cyc();
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        rst_ni = 1'b1;
        cyc();
        t_reset();
        t_order();
        t_overflow();
        t_full_swap();
        t_underflow();
        t_burst();
        t_thresh();
        t_state();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule